// File: doc/BRIEF.md
# Serial Break Reset Requester

This block watches the receive line of an asynchronous serial port and asks for a system reset when the line shows a break. A break is the line held low without interruption for a whole frame time. Frame time is measured in bit periods, using a one-cycle tick from the baud generator. The frame length depends on the selected serial mode. The block does not decode characters. It only measures how long the line has stayed low.

A long break can keep the line low for many frames. The block still raises its request only once per break, and it waits until the line has recovered before it can fire again. A separate enable input gates the request. When the enable is clear, breaks pass without effect. The system uses the request to restart the processor from its boot-loader entry point, so a host can start in-system programming over the same serial link.

Top module: `brk_reset_gen`

## Requirements
- R1: Synchronous active-high reset drives `rst_req` to 0 and leaves the block armed with an idle (high) synchronised line. `rx` reaches the counting logic through a two-stage synchroniser.
- R2: The frame length in bit ticks is 8 when `mode` is 2'd0, 10 when `mode` is 2'd1, and 11 when `mode` is 2'd2 or 2'd3.
- R3: `rst_req` rises on the clock edge after the `bit_tick` at which the count of ticks seen with the synchronised line low reaches the frame length.
- R4: Any cycle in which the synchronised line is high clears the low-tick count, so a one-cycle high glitch restarts the measurement.
- R5: `rst_req` is a registered pulse exactly one clock wide.
- R6: After a request, no further request is issued until the synchronised line has been high at two consecutive bit ticks. A high stretch that covers only one tick does not re-arm the block.
- R7: While `brk_en` is 0 no request is issued, and a break seen in that state does not use up the arming. A later break with `brk_en` at 1 still fires.
- R8: A low run of one tick fewer than the frame length issues no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx | input | 1 | Serial receive line, asynchronous |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| mode | input | 2 | Serial mode, selects the frame length |
| brk_en | input | 1 | Allows a break to request a reset |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its default parameters: frame lengths of 8, 10 and 11 ticks and a two-stage synchroniser. A tick every four clocks lets the synchronised edges settle between ticks, so every run length is exact. Random break lengths from 1 to 16 ticks in all four modes cover the frame limit and the tick just below it. Directed cases cover the following:
- a long break that must fire only once;
- a single-cycle glitch that must restart the count;
- a high stretch one tick short of re-arming;
- a disabled break followed by an enabled one.

// File: rtl/brk_reset_gen.sv
module brk_reset_gen #(
  parameter int MODE0_BITS  = 8,
  parameter int MODE1_BITS  = 10,
  parameter int MODE9_BITS  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  input  logic       bit_tick,
  input  logic [1:0] mode,
  input  logic       brk_en,
  output logic       rst_req
);
  localparam int MAXA  = (MODE0_BITS > MODE1_BITS) ? MODE0_BITS : MODE1_BITS;
  localparam int MAXB  = (MAXA > MODE9_BITS) ? MAXA : MODE9_BITS;
  localparam int CNT_W = $clog2(MAXB + 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic [CNT_W-1:0]       lo_cnt, frame_len, run_next;
  logic                   hi_run, armed, hit;

  always_ff @(posedge clk)
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx};

  assign rx_s = sync_q[SYNC_STAGES-1];

  always_comb
    case (mode)
      2'd0:    frame_len = CNT_W'(MODE0_BITS);
      2'd1:    frame_len = CNT_W'(MODE1_BITS);
      default: frame_len = CNT_W'(MODE9_BITS);
    endcase

  assign run_next = lo_cnt + 1'b1;
  assign hit      = bit_tick & ~rx_s & (run_next == frame_len);

  always_ff @(posedge clk)
    if (rst || rx_s)                                lo_cnt <= '0;
    else if (bit_tick && lo_cnt != CNT_W'(MAXB))    lo_cnt <= run_next;

  always_ff @(posedge clk)
    if (rst || !rx_s)  hi_run <= 1'b0;
    else if (bit_tick) hi_run <= 1'b1;

  always_ff @(posedge clk)
    if (rst)                              armed <= 1'b1;
    else if (hit && brk_en && armed)      armed <= 1'b0;
    else if (rx_s && bit_tick && hi_run)  armed <= 1'b1;

  always_ff @(posedge clk)
    if (rst) rst_req <= 1'b0;
    else     rst_req <= hit & brk_en & armed;

  // R5
  one_wide_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(brk_en));

  // R3
  tick_low_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(bit_tick) && !$past(rx_s)));

  // R4
  high_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rx_s |=> (lo_cnt == '0));

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !armed);
endmodule

// File: tb/brk_reset_gen_bench.sv
module brk_reset_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0, rst = 1'b1, rx = 1'b1, bit_tick = 1'b0, brk_en = 1'b0;
  logic [1:0] mode = 2'd1;
  logic rst_req;
  int checks = 0, fails = 0, pulses = 0, wide = 0, div = 0;
  logic prev_req = 1'b0;

  brk_reset_gen u_brk_reset_gen (.clk(clk), .rst(rst), .rx(rx), .bit_tick(bit_tick),
                                 .mode(mode), .brk_en(brk_en), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div      <= (div == TICK_DIV-1) ? 0 : div + 1;
    bit_tick <= (div == TICK_DIV-1);
    if (rst_req && !prev_req) pulses <= pulses + 1;
    if (rst_req && prev_req)  wide   <= wide + 1;
    prev_req <= rst_req;
  end

  function automatic int flen(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 10 : 11;
  endfunction

  function automatic int exp_pulses(input int n, input logic [1:0] m, input logic en);
    return (en && n >= flen(m)) ? 1 : 0;
  endfunction

  task automatic wait_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk iff bit_tick);
      @(negedge clk);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    wait_tick(n);
  endtask

  task automatic glitch();
    rx = 1'b1;
    @(negedge clk);
    rx = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic got(input string req, input int base, input int exp);
    check(req, pulses - base, exp);
    check("R5", wide, 0);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", int'(rst_req), 0);
    rst = 1'b0;
    wait_tick(1);
    check("R1", int'(rst_req), 0);

    // R3 R2 exact frame in each mode
    brk_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      base = pulses; hold(1'b0, flen(mode)); hold(1'b1, 3);
      got("R2 R3", base, 1);
      // R8 one tick short
      base = pulses; hold(1'b0, flen(mode) - 1); hold(1'b1, 3);
      got("R8", base, 0);
    end

    // R6 long break fires once
    mode = 2'd1;
    base = pulses; hold(1'b0, 40); hold(1'b1, 3);
    got("R6", base, 1);

    // R4 glitch restarts count
    base = pulses; hold(1'b0, 6); glitch(); wait_tick(6); hold(1'b1, 3);
    got("R4", base, 0);
    base = pulses; hold(1'b0, 6); glitch(); wait_tick(10); hold(1'b1, 3);
    got("R4", base, 1);

    // R6 re-arm needs two high ticks
    base = pulses; hold(1'b0, 12); glitch(); wait_tick(12); hold(1'b1, 1);
    hold(1'b0, 12); hold(1'b1, 2);
    got("R6", base, 1);
    base = pulses; hold(1'b0, 12); hold(1'b1, 3);
    got("R6", base, 1);

    // R7 disabled break leaves block armed
    brk_en = 1'b0;
    base = pulses; hold(1'b0, 20); hold(1'b1, 3);
    got("R7", base, 0);
    brk_en = 1'b1;
    base = pulses; hold(1'b0, 10); hold(1'b1, 3);
    got("R7", base, 1);

    // random mix
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 60; i++) begin
      int n;
      mode   = 2'($urandom_range(0, 3));
      brk_en = 1'($urandom_range(0, 1));
      n      = $urandom_range(1, 16);
      base = pulses; hold(1'b0, n); hold(1'b1, 3);
      got("R3 R7", base, exp_pulses(n, mode, brk_en));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule